// File: doc/BRIEF.md
# Splittable Dual-Half Interval Timer

This block is a general-purpose interval timer made of two 16-bit counter halves, called A and B. A configuration bit either fuses the halves into one 32-bit counter, with A as the low half and B as the high half, or keeps them apart as two independent 16-bit timers. Each half has its own interval (load) value, match value, 8-bit prescaler, run bit and mode. The mode selects one-shot, periodic or PWM operation and the count direction.

Software drives a plain register port. Writes take effect at the clock edge. Reads are combinational from `rd_addr`. The port has no handshake, because every access completes in one cycle. Each half raises a one-cycle timeout pulse and a one-cycle match pulse, and drives a level PWM output. In fused mode all status appears on the A outputs, and the B outputs stay low.

Register addresses (4 bits): 0 = config (bit 0 fuses the halves), 1 = run bits (bit 0 runs A, bit 1 runs B), 2/3 = mode of A/B, 4/5 = load of A/B, 6/7 = match of A/B, 8/9 = prescale of A/B, 10/11 = current count of A/B (read only). A mode word is made of bits [1:0] and bit 2. Bits [1:0] select 0 = one-shot, 1 = periodic, 2 = PWM, 3 = periodic. Bit 2 set means count up.

Top module: `split_timer`

## Requirements
- R1: After reset both counts and both load values read 0xFFFF. Prescale, match, mode, run and config read 0. All outputs are low.
- R2: A write stores its field at the clock edge. A write to a load register also sets that half's count to the written value, overriding any count step in the same cycle. A read returns the addressed field zero-extended, and the count at addresses 10/11.
- R3: On a count tick, a down-counting half that holds 0 reloads its load value, and its timeout output is high for exactly the next cycle. On any other tick it decrements by one.
- R4: On a count tick, an up-counting half that holds its load value wraps to 0 and raises timeout for one cycle. On any other tick it increments by one.
- R5: A one-shot half clears its own run bit on the tick that raises timeout, and then holds its count. Periodic and PWM halves keep running.
- R6: A running half ticks once every (prescale + 1) cycles. A half that is not running holds its count, and its prescaler restarts from zero.
- R7: The match output is high for one cycle after a tick whose new count equals the match value.
- R8: In PWM mode the PWM output is high while the count has not yet passed the match value: down-counting `count > match`, up-counting `count < match`. In other modes the output is low.
- R9: With the config bit set, {B,A} forms one 32-bit counter that uses A's run bit, mode and prescaler and the 32-bit load and match values {B,A}. A borrow or carry moves into B in the same cycle, and the B outputs stay low.
- R10: With the config bit clear, the halves count independently, each with its own run bit, mode, direction and prescale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| timeout_a | output | 1 | Half A (or fused) timeout pulse |
| timeout_b | output | 1 | Half B timeout pulse |
| match_a | output | 1 | Half A (or fused) match pulse |
| match_b | output | 1 | Half B match pulse |
| pwm_a | output | 1 | Half A (or fused) PWM level |
| pwm_b | output | 1 | Half B PWM level |

## Verification
The bench goes after these corner cases:
- The borrow from A into B at the 0x0000 boundary in fused mode. A design without the same-cycle carry would leave B at 1 while A wraps.
- A one-shot expiry. A design that forgets to clear the run bit would keep reloading.
- Prescale values above zero. An off-by-one divider would tick every prescale or every prescale + 2 cycles.
- Load writes that land on a tick, and the match and PWM edge at the match value.

Randomized writes run against a cycle model in the bench, so that mode changes, prescaler restarts and split/fused switching all happen in the middle of a count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CFG     = 4'd0,
    ADR_CTRL    = 4'd1,
    ADR_MODE_A  = 4'd2,
    ADR_MODE_B  = 4'd3,
    ADR_LOAD_A  = 4'd4,
    ADR_LOAD_B  = 4'd5,
    ADR_MATCH_A = 4'd6,
    ADR_MATCH_B = 4'd7,
    ADR_PRE_A   = 4'd8,
    ADR_PRE_B   = 4'd9,
    ADR_CNT_A   = 4'd10,
    ADR_CNT_B   = 4'd11
  } reg_addr_e;

  typedef enum logic [1:0] {
    MD_ONESHOT  = 2'd0,
    MD_PERIODIC = 2'd1,
    MD_PWM      = 2'd2,
    MD_SPARE    = 2'd3
  } run_mode_e;

  typedef struct packed {
    logic      up;
    run_mode_e mode;
  } half_mode_t;

  localparam int MODE_W = $bits(half_mode_t);
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] pre,
  output logic          tick
);
  logic [PW-1:0] pcnt;

  assign tick = en && (pcnt == pre);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!en || tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] load,
  input  logic [W-1:0] mval,
  input  half_mode_t   mode,
  input  logic         tick,
  output logic [W-1:0] nxt,
  output logic         tmo,
  output logic         hit,
  output logic         stop,
  output logic         pwm
);
  logic         at_end;
  logic [W-1:0] step;

  always_comb begin
    at_end = mode.up ? (cur == load) : (cur == '0);
    if (mode.up) begin
      step = at_end ? '0 : cur + 1'b1;
    end else begin
      step = at_end ? load : cur - 1'b1;
    end
    nxt  = tick ? step : cur;
    tmo  = tick && at_end;
    hit  = tick && (step == mval);
    stop = tmo && (mode.mode == MD_ONESHOT);
    pwm  = mode.up ? (cur < mval) : (cur > mval);
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int HW = 16,
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              stop_a,
  input  logic              stop_b,
  input  logic [HW-1:0]     cnt_a,
  input  logic [HW-1:0]     cnt_b,
  output logic [HW-1:0]     rd_data,
  output logic              fuse,
  output logic              run_a,
  output logic              run_b,
  output half_mode_t        mode_a,
  output half_mode_t        mode_b,
  output logic [HW-1:0]     load_a,
  output logic [HW-1:0]     load_b,
  output logic [HW-1:0]     mval_a,
  output logic [HW-1:0]     mval_b,
  output logic [PW-1:0]     pre_a,
  output logic [PW-1:0]     pre_b,
  output logic              ld_wr_a,
  output logic              ld_wr_b,
  output logic              ctrl_wr
);
  assign ld_wr_a = wr_en && (wr_addr == ADR_LOAD_A);
  assign ld_wr_b = wr_en && (wr_addr == ADR_LOAD_B);
  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fuse   <= 1'b0;
      run_a  <= 1'b0;
      run_b  <= 1'b0;
      mode_a <= '0;
      mode_b <= '0;
      load_a <= '1;
      load_b <= '1;
      mval_a <= '0;
      mval_b <= '0;
      pre_a  <= '0;
      pre_b  <= '0;
    end else begin
      if (stop_a) run_a <= 1'b0;
      if (stop_b) run_b <= 1'b0;
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          ADR_CFG:     fuse <= wr_data[0];
          ADR_CTRL: begin
            run_a <= wr_data[0];
            run_b <= wr_data[1];
          end
          ADR_MODE_A:  mode_a <= half_mode_t'(wr_data[MODE_W-1:0]);
          ADR_MODE_B:  mode_b <= half_mode_t'(wr_data[MODE_W-1:0]);
          ADR_LOAD_A:  load_a <= wr_data;
          ADR_LOAD_B:  load_b <= wr_data;
          ADR_MATCH_A: mval_a <= wr_data;
          ADR_MATCH_B: mval_b <= wr_data;
          ADR_PRE_A:   pre_a  <= wr_data[PW-1:0];
          ADR_PRE_B:   pre_b  <= wr_data[PW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      ADR_CFG:     rd_data[0] = fuse;
      ADR_CTRL:    rd_data[1:0] = {run_b, run_a};
      ADR_MODE_A:  rd_data[MODE_W-1:0] = mode_a;
      ADR_MODE_B:  rd_data[MODE_W-1:0] = mode_b;
      ADR_LOAD_A:  rd_data = load_a;
      ADR_LOAD_B:  rd_data = load_b;
      ADR_MATCH_A: rd_data = mval_a;
      ADR_MATCH_B: rd_data = mval_b;
      ADR_PRE_A:   rd_data[PW-1:0] = pre_a;
      ADR_PRE_B:   rd_data[PW-1:0] = pre_b;
      ADR_CNT_A:   rd_data = cnt_a;
      ADR_CNT_B:   rd_data = cnt_b;
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/split_timer.sv
module split_timer
  import tmr_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0] rd_data,
  output logic              timeout_a,
  output logic              timeout_b,
  output logic              match_a,
  output logic              match_b,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int FULL_W = 2 * HALF_W;

  logic              fuse, run_a, run_b, stop_a, stop_b;
  logic              ctrl_wr, ld_wr_a, ld_wr_b, tick_a, tick_b;
  half_mode_t        mode_a, mode_b;
  logic [HALF_W-1:0] load_a, load_b, mval_a, mval_b, cnt_a, cnt_b;
  logic [HALF_W-1:0] cnt_a_d, cnt_b_d;
  logic [PRE_W-1:0]  pre_a, pre_b;

  logic [HALF_W-1:0] a_nxt, b_nxt;
  logic [FULL_W-1:0] f_nxt;
  logic a_tmo, a_hit, a_stop, a_pwm;
  logic b_tmo, b_hit, b_stop, b_pwm;
  logic f_tmo, f_hit, f_stop, f_pwm;

  tmr_regs #(.HW(HALF_W), .PW(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .stop_a(stop_a), .stop_b(stop_b),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .rd_data(rd_data), .fuse(fuse),
    .run_a(run_a), .run_b(run_b), .mode_a(mode_a), .mode_b(mode_b),
    .load_a(load_a), .load_b(load_b), .mval_a(mval_a), .mval_b(mval_b),
    .pre_a(pre_a), .pre_b(pre_b), .ld_wr_a(ld_wr_a), .ld_wr_b(ld_wr_b),
    .ctrl_wr(ctrl_wr)
  );

  // Half A's prescaler also paces the fused counter; B's idles when fused.
  tmr_prescale #(.PW(PRE_W)) u_pre_a (
    .clk(clk), .rst_n(rst_n), .en(run_a), .pre(pre_a), .tick(tick_a)
  );
  tmr_prescale #(.PW(PRE_W)) u_pre_b (
    .clk(clk), .rst_n(rst_n), .en(run_b && !fuse), .pre(pre_b), .tick(tick_b)
  );

  tmr_count #(.W(HALF_W)) u_cnt_a (
    .cur(cnt_a), .load(load_a), .mval(mval_a), .mode(mode_a), .tick(tick_a),
    .nxt(a_nxt), .tmo(a_tmo), .hit(a_hit), .stop(a_stop), .pwm(a_pwm)
  );
  tmr_count #(.W(HALF_W)) u_cnt_b (
    .cur(cnt_b), .load(load_b), .mval(mval_b), .mode(mode_b), .tick(tick_b),
    .nxt(b_nxt), .tmo(b_tmo), .hit(b_hit), .stop(b_stop), .pwm(b_pwm)
  );
  // Fused view: the borrow/carry between halves is implicit in the wide add.
  tmr_count #(.W(FULL_W)) u_cnt_f (
    .cur({cnt_b, cnt_a}), .load({load_b, load_a}), .mval({mval_b, mval_a}),
    .mode(mode_a), .tick(tick_a),
    .nxt(f_nxt), .tmo(f_tmo), .hit(f_hit), .stop(f_stop), .pwm(f_pwm)
  );

  assign stop_a = fuse ? f_stop : a_stop;
  assign stop_b = !fuse && b_stop;

  always_comb begin
    cnt_a_d = fuse ? f_nxt[HALF_W-1:0]      : a_nxt;
    cnt_b_d = fuse ? f_nxt[FULL_W-1:HALF_W] : b_nxt;
    if (ld_wr_a) cnt_a_d = wr_data;
    if (ld_wr_b) cnt_b_d = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a     <= '1;
      cnt_b     <= '1;
      timeout_a <= 1'b0;
      timeout_b <= 1'b0;
      match_a   <= 1'b0;
      match_b   <= 1'b0;
    end else begin
      cnt_a     <= cnt_a_d;
      cnt_b     <= cnt_b_d;
      timeout_a <= fuse ? f_tmo : a_tmo;
      match_a   <= fuse ? f_hit : a_hit;
      timeout_b <= !fuse && b_tmo;
      match_b   <= !fuse && b_hit;
    end
  end

  assign pwm_a = (mode_a.mode == MD_PWM) && (fuse ? f_pwm : a_pwm);
  assign pwm_b = !fuse && (mode_b.mode == MD_PWM) && b_pwm;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fuse,
  input logic          run_a,
  input logic          stop_a,
  input logic          ctrl_wr,
  input logic          ld_wr_a,
  input logic          tick_a,
  input logic [HW-1:0] cnt_a,
  input half_mode_t    mode_b,
  input logic          timeout_a,
  input logic          match_a,
  input logic          timeout_b,
  input logic          match_b,
  input logic          pwm_b
);
  assert_fused_b_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse && $past(fuse)) |-> (!timeout_b && !match_b && !pwm_b));

  assert_oneshot_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_a && !ctrl_wr) |=> !run_a);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a && !ld_wr_a) |=> $stable(cnt_a));

  assert_flags_need_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_a |=> (!timeout_a && !match_a));

  assert_pwm_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b.mode != MD_PWM) |-> !pwm_b);
endmodule

bind split_timer tmr_checker #(.HW(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fuse(fuse), .run_a(run_a), .stop_a(stop_a),
  .ctrl_wr(ctrl_wr), .ld_wr_a(ld_wr_a), .tick_a(tick_a), .cnt_a(cnt_a),
  .mode_b(mode_b), .timeout_a(timeout_a), .match_a(match_a),
  .timeout_b(timeout_b), .match_b(match_b), .pwm_b(pwm_b)
);

// File: tb/split_timer_test.sv
`timescale 1ns/1ps
module split_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic timeout_a, timeout_b, match_a, match_b, pwm_a, pwm_b;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  split_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .timeout_a(timeout_a), .timeout_b(timeout_b), .match_a(match_a),
    .match_b(match_b), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // Bench cycle model, written from the requirements
  bit        m_fuse;
  bit [1:0]  m_run;
  bit [2:0]  m_mode [2];
  bit [15:0] m_load [2];
  bit [15:0] m_mval [2];
  bit [15:0] m_cnt  [2];
  bit [7:0]  m_pre  [2];
  bit [7:0]  m_pc   [2];
  bit        m_tmo  [2];
  bit        m_hit  [2];

  task automatic model_reset();
    m_fuse = 0; m_run = 0;
    for (int h = 0; h < 2; h++) begin
      m_mode[h] = 0; m_load[h] = 16'hFFFF; m_mval[h] = 0; m_cnt[h] = 16'hFFFF;
      m_pre[h] = 0; m_pc[h] = 0; m_tmo[h] = 0; m_hit[h] = 0;
    end
  endtask

  function automatic void adv(input bit [31:0] cur, input bit [31:0] ld,
                              input bit [31:0] mv, input bit up,
                              input bit [31:0] msk, input bit tk,
                              output bit [31:0] nx, output bit t, output bit hh);
    bit e;
    bit [31:0] s;
    e = up ? (cur == ld) : (cur == 0);
    if (up) s = e ? 32'd0 : ((cur + 1) & msk);
    else    s = e ? ld : ((cur - 1) & msk);
    nx = tk ? s : cur;
    t  = tk && e;
    hh = tk && (s == mv);
  endfunction

  task automatic model_step();
    bit en [2];
    bit tk [2];
    bit [15:0] nc [2];
    bit [31:0] nx;
    bit t, hh;
    en[0] = m_run[0];
    en[1] = m_run[1] && !m_fuse;
    for (int h = 0; h < 2; h++) tk[h] = en[h] && (m_pc[h] == m_pre[h]);
    if (m_fuse) begin
      adv({m_cnt[1], m_cnt[0]}, {m_load[1], m_load[0]}, {m_mval[1], m_mval[0]},
          m_mode[0][2], 32'hFFFF_FFFF, tk[0], nx, t, hh);
      nc[0] = nx[15:0]; nc[1] = nx[31:16];
      m_tmo[0] = t; m_hit[0] = hh; m_tmo[1] = 0; m_hit[1] = 0;
      if (t && m_mode[0][1:0] == 2'd0) m_run[0] = 0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        adv({16'd0, m_cnt[h]}, {16'd0, m_load[h]}, {16'd0, m_mval[h]},
            m_mode[h][2], 32'h0000_FFFF, tk[h], nx, t, hh);
        nc[h] = nx[15:0]; m_tmo[h] = t; m_hit[h] = hh;
        if (t && m_mode[h][1:0] == 2'd0) m_run[h] = 0;
      end
    end
    for (int h = 0; h < 2; h++) begin
      if (!en[h] || tk[h]) m_pc[h] = 0;
      else m_pc[h] = m_pc[h] + 1;
    end
    if (wr_en) begin
      case (wr_addr)
        4'd0: m_fuse = wr_data[0];
        4'd1: m_run = wr_data[1:0];
        4'd2: m_mode[0] = wr_data[2:0];
        4'd3: m_mode[1] = wr_data[2:0];
        4'd4: begin m_load[0] = wr_data; nc[0] = wr_data; end
        4'd5: begin m_load[1] = wr_data; nc[1] = wr_data; end
        4'd6: m_mval[0] = wr_data;
        4'd7: m_mval[1] = wr_data;
        4'd8: m_pre[0] = wr_data[7:0];
        4'd9: m_pre[1] = wr_data[7:0];
        default: ;
      endcase
    end
    m_cnt[0] = nc[0]; m_cnt[1] = nc[1];
  endtask

  function automatic bit [15:0] mread(input bit [3:0] a);
    case (a)
      4'd0: return {15'd0, m_fuse};
      4'd1: return {14'd0, m_run};
      4'd2: return {13'd0, m_mode[0]};
      4'd3: return {13'd0, m_mode[1]};
      4'd4: return m_load[0];
      4'd5: return m_load[1];
      4'd6: return m_mval[0];
      4'd7: return m_mval[1];
      4'd8: return {8'd0, m_pre[0]};
      4'd9: return {8'd0, m_pre[1]};
      4'd10: return m_cnt[0];
      4'd11: return m_cnt[1];
      default: return 16'd0;
    endcase
  endfunction

  function automatic bit exp_pwm(input int h);
    bit [31:0] c, mv;
    bit up;
    if (h == 1 && m_fuse) return 0;
    if (m_mode[h][1:0] != 2'd2) return 0;
    if (m_fuse) begin
      c = {m_cnt[1], m_cnt[0]}; mv = {m_mval[1], m_mval[0]}; up = m_mode[0][2];
    end else begin
      c = {16'd0, m_cnt[h]}; mv = {16'd0, m_mval[h]}; up = m_mode[h][2];
    end
    return up ? (c < mv) : (c > mv);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3 timeout_a", timeout_a, m_tmo[0]);
    chk(m_fuse ? "R9 timeout_b" : "R3 timeout_b", timeout_b, m_tmo[1]);
    chk("R7 match_a", match_a, m_hit[0]);
    chk(m_fuse ? "R9 match_b" : "R7 match_b", match_b, m_hit[1]);
    chk("R8 pwm_a", pwm_a, exp_pwm(0));
    chk(m_fuse ? "R9 pwm_b" : "R8 pwm_b", pwm_b, exp_pwm(1));
    chk("R2 rd_data", rd_data, mread(rd_addr));
  endtask

  task automatic cyc(input bit w, input bit [3:0] a, input bit [15:0] d, input bit [3:0] r);
    wr_en = w; wr_addr = a; wr_data = d; rd_addr = r;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd5021));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cyc(0, 0, 0, 4'd4);  chk("R1 load_a", rd_data, 16'hFFFF);
    cyc(0, 0, 0, 4'd5);  chk("R1 load_b", rd_data, 16'hFFFF);
    cyc(0, 0, 0, 4'd10); chk("R1 cnt_a", rd_data, 16'hFFFF);
    cyc(0, 0, 0, 4'd11); chk("R1 cnt_b", rd_data, 16'hFFFF);
    cyc(0, 0, 0, 4'd8);  chk("R1 pre_a", rd_data, 16'h0000);
    cyc(0, 0, 0, 4'd1);  chk("R1 run", rd_data, 16'h0000);
    chk("R1 outputs", {timeout_a, timeout_b, match_a, match_b, pwm_a, pwm_b}, 0);

    // R3: periodic down count, load 3
    cyc(1, 4'd2, 16'd1, 4'd10);
    cyc(1, 4'd4, 16'd3, 4'd10);
    chk("R2 load sets count", rd_data, 16'd3);
    cyc(1, 4'd1, 16'd1, 4'd10);
    for (int i = 1; i <= 4; i++) begin
      cyc(0, 0, 0, 4'd10);
      if (i == 3) chk("R3 reaches zero", rd_data, 16'd0);
      if (i == 4) begin
        chk("R3 reload", rd_data, 16'd3);
        chk("R3 timeout pulse", timeout_a, 1'b1);
      end
    end
    cyc(1, 4'd1, 16'd0, 4'd10);

    // R4: periodic up count wraps at load
    cyc(1, 4'd2, 16'd5, 4'd10);
    cyc(1, 4'd4, 16'd2, 4'd10);
    cyc(1, 4'd1, 16'd1, 4'd10);
    cyc(0, 0, 0, 4'd10);
    chk("R4 wrap to zero", rd_data, 16'd0);
    chk("R4 timeout", timeout_a, 1'b1);
    cyc(0, 0, 0, 4'd10); cyc(0, 0, 0, 4'd10);
    chk("R4 count up", rd_data, 16'd2);
    cyc(0, 0, 0, 4'd10);
    chk("R4 second wrap", timeout_a, 1'b1);
    cyc(1, 4'd1, 16'd0, 4'd10);

    // R5: one-shot stops after expiry
    cyc(1, 4'd2, 16'd0, 4'd10);
    cyc(1, 4'd4, 16'd1, 4'd10);
    cyc(1, 4'd1, 16'd1, 4'd10);
    cyc(0, 0, 0, 4'd10);
    cyc(0, 0, 0, 4'd1);
    chk("R5 run cleared", rd_data, 16'd0);
    chk("R5 timeout", timeout_a, 1'b1);
    cyc(0, 0, 0, 4'd10);
    cyc(0, 0, 0, 4'd10);
    chk("R5 count held", rd_data, 16'd1);

    // R6: prescale of 2 -> one tick per 3 cycles
    cyc(1, 4'd2, 16'd1, 4'd10);
    cyc(1, 4'd8, 16'd2, 4'd10);
    cyc(1, 4'd4, 16'd100, 4'd10);
    cyc(1, 4'd1, 16'd1, 4'd10);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 4'd10);
    chk("R6 prescaled count", rd_data, 16'd98);
    cyc(1, 4'd1, 16'd0, 4'd10);
    cyc(0, 0, 0, 4'd10); cyc(0, 0, 0, 4'd10);
    chk("R6 idle holds", rd_data, 16'd98);
    cyc(1, 4'd8, 16'd0, 4'd10);

    // R8 / R7: PWM down with match 2
    cyc(1, 4'd2, 16'd2, 4'd10);
    cyc(1, 4'd6, 16'd2, 4'd10);
    cyc(1, 4'd4, 16'd4, 4'd10);
    chk("R8 pwm high before match", pwm_a, 1'b1);
    cyc(1, 4'd1, 16'd1, 4'd10);
    cyc(0, 0, 0, 4'd10);
    cyc(0, 0, 0, 4'd10);
    chk("R8 pwm low at match", pwm_a, 1'b0);
    chk("R7 match pulse", match_a, 1'b1);
    cyc(1, 4'd1, 16'd0, 4'd10);
    cyc(1, 4'd6, 16'd0, 4'd10);

    // R9: fused borrow from A into B
    cyc(1, 4'd0, 16'd1, 4'd10);
    cyc(1, 4'd2, 16'd1, 4'd10);
    cyc(1, 4'd5, 16'd1, 4'd10);
    cyc(1, 4'd4, 16'd0, 4'd10);
    cyc(1, 4'd1, 16'd3, 4'd10);
    cyc(0, 0, 0, 4'd10);
    chk("R9 low half wraps", rd_data, 16'hFFFF);
    cyc(0, 0, 0, 4'd11);
    chk("R9 borrow into high", rd_data, 16'd0);
    chk("R9 b outputs low", {timeout_b, match_b, pwm_b}, 0);
    cyc(1, 4'd1, 16'd0, 4'd10);
    cyc(1, 4'd0, 16'd0, 4'd10);

    // R10: split halves, A up, B down with prescale 1
    cyc(1, 4'd2, 16'd5, 4'd10);
    cyc(1, 4'd3, 16'd1, 4'd10);
    cyc(1, 4'd9, 16'd1, 4'd10);
    cyc(1, 4'd4, 16'd50, 4'd10);
    cyc(1, 4'd5, 16'd20, 4'd10);
    cyc(1, 4'd1, 16'd3, 4'd10);
    for (int i = 1; i <= 4; i++) cyc(0, 0, 0, 4'd10);
    chk("R10 half A", rd_data, 16'd3);
    cyc(0, 0, 0, 4'd11);
    chk("R10 half B", rd_data, 16'd18);
    cyc(1, 4'd1, 16'd0, 4'd10);

    // Random phase against the cycle model
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      bit [3:0] a;
      bit [15:0] d;
      sel = $urandom_range(0, 7);
      if (sel == 0) begin
        a = 4'($urandom_range(0, 9));
        case (a)
          4'd0: d = ($urandom_range(0, 3) == 0) ? 16'd1 : 16'd0;
          4'd1: d = 16'($urandom_range(0, 3));
          4'd2, 4'd3: d = 16'($urandom_range(0, 7));
          4'd8, 4'd9: d = 16'($urandom_range(0, 3));
          default: d = 16'($urandom_range(0, 40));
        endcase
        cyc(1, a, d, 4'($urandom_range(0, 11)));
      end else begin
        cyc(0, 0, 0, 4'($urandom_range(0, 11)));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule